// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Software Acknowledge

This block collects a set of level-sensitive interrupt request lines and picks a winning source for software. Each source carries a programmable 3-bit level and a 3-bit priority within that level, and a mask bit can hold it back. Arbitration has two tiers. The level is compared first. Among sources at the same level, the priority decides. A remaining tie goes to the lower source index.

Software polls the block through a small register port. A read of the general acknowledge location returns the vector of the best unmasked pending source. A read of one of seven per-level acknowledge locations returns the best source at that level only. Every acknowledge read also loads a capture register with the level and priority of the source it returned. This lets a service routine chain straight into the next pending handler without taking a new exception.

Register map (word addresses, 6-bit address):
- 0x00: mask
- 0x01: capture
- 0x08: general acknowledge
- 0x09–0x0F: acknowledge for levels 1–7
- 0x20+i: configuration of source i

Top module: `intc_swack`

## Requirements
- R1: A read of address 0x08 returns, one cycle after the read strobe, the vector 64+i of the eligible source i with the highest level. Among equal levels the highest priority wins, and a full tie goes to the lowest index. A source is eligible when it is pending, unmasked and has a nonzero level.
- R2: Every acknowledge read (0x08–0x0F) loads the capture register (read at 0x01) with the returned source's level in bits 6:4 and its priority in bits 2:0; all other bits are zero. Other reads and all writes leave the capture register unchanged.
- R3: When no eligible source exists at an acknowledge read, the returned data is zero and the capture register is cleared.
- R4: A read of address 0x08+n (n = 1..7) returns the vector of the best eligible source whose level equals n, ignoring other levels. It returns zero and clears the capture register if there is none.
- R5: Acknowledge and capture locations are read-only: writes to them have no effect. After reset the read data and the capture register are zero.
- R6: Mask register at 0x00 holds one bit per source, where bit i = 1 masks source i. It resets to all ones and reads back what was written. A masked source is never returned by any acknowledge read.
- R7: A source whose level is 0 is never returned, even when pending and unmasked.
- R8: The configuration word at 0x20+i holds the level in bits 6:4 and the priority in bits 2:0. It reads back as written and resets to zero.
- R9: Request inputs are registered once. A request that changes on the cycle of a read strobe is not yet seen by that read, but is seen by a strobe one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_SRC | Level-sensitive interrupt requests |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
Directed patterns separate the arbitration tiers:
- One source at a higher level with a low priority must beat higher-priority sources below it, which shows the level is compared first.
- Two sources with equal level and priority expose the index tie-break.
- Masking the current winner, or giving a pending source level 0, shows that the next candidate takes over.

Per-level reads are tried at a populated level and at an empty one, so filtering and the empty-level zero are told apart. A request that changes together with the read strobe shows the one-cycle input register. Randomised configuration, mask and request patterns, followed by reads of both kinds of acknowledge and of the capture register, then cover the combinations the directed cases miss.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVL_W     = 3;
    localparam int PRI_W     = 3;
    localparam int VEC_W     = 8;
    localparam int DATA_W    = 32;
    localparam int VEC_BASE  = 64;
    localparam int MASK_ADDR = 'h00;
    localparam int CAP_ADDR  = 'h01;
    localparam int ACK_BASE  = 'h08;
    localparam int CFG_BASE  = 'h20;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PRI_W-1:0] pri_t;
    typedef logic [VEC_W-1:0] vec_t;

    function automatic logic [7:0] pack_lp(lvl_t l, pri_t p);
        return {1'b0, l, 1'b0, p};
    endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_SRC-1:0]            mask_q,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
    output logic [NUM_SRC-1:0][PRI_W-1:0] pri_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0]            mask;
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
        logic [NUM_SRC-1:0][PRI_W-1:0] pri;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wdata_unused;
    assign wdata_unused = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == ADDR_W'(MASK_ADDR))
                cfg_d.mask = wdata[NUM_SRC-1:0];
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr == ADDR_W'(CFG_BASE + i)) begin
                    cfg_d.lvl[i] = wdata[6:4];
                    cfg_d.pri[i] = wdata[2:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.lvl  <= '0;
            cfg_q.pri  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_q = cfg_q.mask;
    assign lvl_q  = cfg_q.lvl;
    assign pri_q  = cfg_q.pri;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(lvl_q) && $stable(pri_q))); // R8
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic [NUM_SRC-1:0][PRI_W-1:0] pri,
    input  lvl_t                          sel_lvl,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx,
    output lvl_t                          win_lvl,
    output pri_t                          win_pri
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        win_pri = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (sel_lvl == '0 || lvl[i] == sel_lvl)) begin
                if (!found || {lvl[i], pri[i]} > {win_lvl, win_pri}) begin
                    found   = 1'b1;
                    win_idx = IDX_W'(i);
                    win_lvl = lvl[i];
                    win_pri = pri[i];
                end
            end
        end
    end
endmodule

// File: rtl/intc_swack.sv
module intc_swack
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 6,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic [31:0]        rdata;
        logic [7:0]         cap;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC-1:0]            mask_q;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [NUM_SRC-1:0][PRI_W-1:0] pri_q;
    logic [NUM_SRC-1:0]            elig;
    logic                          found;
    logic [IDX_W-1:0]              win_idx;
    lvl_t                          win_lvl;
    pri_t                          win_pri;
    logic                          is_ack;
    lvl_t                          sel_lvl;

    intc_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .mask_q(mask_q), .lvl_q(lvl_q), .pri_q(pri_q)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = st_q.req[g] && !mask_q[g] && (lvl_q[g] != '0);
    end

    assign is_ack  = rd_en_i && (addr_i[ADDR_W-1:3] == (ADDR_W-3)'(ACK_BASE >> 3));
    assign sel_lvl = addr_i[2:0];

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .elig(elig), .lvl(lvl_q), .pri(pri_q), .sel_lvl(sel_lvl),
        .found(found), .win_idx(win_idx), .win_lvl(win_lvl), .win_pri(win_pri)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = irq_i;
        if (rd_en_i) begin
            st_d.rdata = '0;
            if (is_ack) begin
                if (found) begin
                    st_d.rdata = 32'(VEC_W'(VEC_BASE) + VEC_W'(win_idx));
                    st_d.cap   = pack_lp(win_lvl, win_pri);
                end else begin
                    st_d.cap   = '0;
                end
            end else if (addr_i == ADDR_W'(MASK_ADDR)) begin
                st_d.rdata = 32'(mask_q);
            end else if (addr_i == ADDR_W'(CAP_ADDR)) begin
                st_d.rdata = 32'(st_q.cap);
            end else begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (addr_i == ADDR_W'(CFG_BASE + i))
                        st_d.rdata = 32'(pack_lp(lvl_q[i], pri_q[i]));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    AST_ACK_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ack && found) |=> (rdata_o >= 32'(VEC_BASE) && rdata_o < 32'(VEC_BASE + NUM_SRC))); // R1
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ack |=> $stable(st_q.cap)); // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ack && !found) |=> (rdata_o == '0 && st_q.cap == '0)); // R3
    AST_LEVEL_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (found && sel_lvl != '0) |-> (win_lvl == sel_lvl)); // R4
    AST_MASKED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !mask_q[win_idx]); // R6
    AST_LVL0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (lvl_q[win_idx] != '0)); // R7
endmodule

// File: tb/sim_intc_swack.sv
module sim_intc_swack;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;

    logic [N-1:0]      mask_m = '1;
    logic [N-1:0][2:0] lvl_m = '0;
    logic [N-1:0][2:0] pri_m = '0;
    logic [7:0]        cap_m = '0;

    always #10 clk = ~clk;

    intc_swack #(.NUM_SRC(N), .ADDR_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    // returns {vector, capture}
    function automatic logic [15:0] model(input logic [N-1:0] rq, input logic [2:0] sel);
        logic ok = 1'b0;
        logic [5:0] bk = '0;
        logic [7:0] v = '0;
        for (int i = 0; i < N; i++) begin
            if (rq[i] && !mask_m[i] && lvl_m[i] != 0 && (sel == 0 || lvl_m[i] == sel)) begin
                if (!ok || {lvl_m[i], pri_m[i]} > bk) begin
                    ok = 1'b1; bk = {lvl_m[i], pri_m[i]}; v = 8'(64 + i);
                end
            end
        end
        return ok ? {v, 1'b0, bk[5:3], 1'b0, bk[2:0]} : 16'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
        if (a == 6'h00) mask_m = d[N-1:0];
        if (a >= 6'h20 && a < 6'h20 + N) begin
            lvl_m[a - 6'h20] = d[6:4]; pri_m[a - 6'h20] = d[2:0];
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic ack(input logic [2:0] sel, input string req);
        logic [15:0] e;
        logic [31:0] d;
        e = model(irq, sel);
        rd(6'h08 + 6'(sel), d);
        cap_m = e[7:0];
        chk(req, d, 32'(e[15:8]));
        rd(6'h01, d);
        chk({req, " capture"}, d, 32'(cap_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] e;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset rdata", rdata, 32'h0);
        rd(6'h00, d); chk("R6 mask reset", d, 32'(16'hFFFF));
        rd(6'h01, d); chk("R5 capture reset", d, 32'h0);
        rd(6'h25, d); chk("R8 cfg reset", d, 32'h0);
        irq = '1;
        ack(3'd0, "R3 all masked");

        // configuration and tiers
        wr(6'h23, 32'h52); wr(6'h27, 32'h56); wr(6'h21, 32'h60); wr(6'h29, 32'h56);
        rd(6'h27, d); chk("R8 cfg readback", d, 32'h56);
        wr(6'h00, 32'h0);
        rd(6'h00, d); chk("R6 mask readback", d, 32'h0);
        irq = '0; irq[3] = 1; irq[7] = 1; irq[9] = 1;
        ack(3'd0, "R1 tie lower index");
        chk("R1 tie vector literal", 32'(model(irq, 0) >> 8), 32'd71);
        irq[1] = 1;
        ack(3'd0, "R1 level beats priority");
        ack(3'd5, "R4 level five");
        ack(3'd3, "R4 empty level");
        rd(6'h01, d); chk("R4 empty level clears capture", d, 32'h0);
        wr(6'h00, 32'h0080);
        ack(3'd5, "R6 masked winner skipped");
        // level 0 source
        irq = '0; irq[2] = 1;
        ack(3'd0, "R7 level zero ignored");
        irq[3] = 1;
        ack(3'd0, "R2 capture load");
        // writes to read-only locations
        wr(6'h08, 32'hFF); wr(6'h01, 32'hFF);
        rd(6'h01, d); chk("R5 capture write ignored", d, 32'(cap_m));
        rd(6'h00, d); chk("R2 non-ack read keeps capture", d, 32'(mask_m));
        rd(6'h01, d); chk("R2 capture after non-ack", d, 32'(cap_m));
        ack(3'd0, "R5 ack after write");
        // input register timing
        e = model(irq, 0);
        @(negedge clk); irq = '0; irq[1] = 1; rd_en = 1'b1; addr = 6'h08;
        @(negedge clk); rd_en = 1'b0;
        chk("R9 same-cycle change unseen", rdata, 32'(e[15:8]));
        cap_m = e[7:0];
        ack(3'd0, "R9 seen next cycle");

        // constrained random
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(3) == 0)
                wr(6'h20 + 6'($urandom_range(N-1)), 32'($urandom_range(127)));
            if ($urandom_range(3) == 0)
                wr(6'h00, 32'($urandom_range(16'hFFFF)) & 32'($urandom_range(16'hFFFF)));
            irq = N'($urandom);
            ack(3'($urandom_range(7)), "R1 R4 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule